// File: doc/BRIEF.md
# Serial Unlock Pattern Matcher

This block sits beside an SRAM and watches its bus cycles as reported by a synchronous bus monitor. Each monitored access comes in as a one-cycle strobe: a read strobe or a write strobe, qualified by a chip-select flag, together with the value of data bit 0. A hidden register bank can only be reached after software writes a fixed 64-bit key, one bit per write cycle on data bit 0. Until the whole key has been seen, every access is an ordinary memory access.

A pointer into the key moves forward by one bit on each write whose data bit matches the key bit at the pointer. If a write does not match, the sequence freezes. Every write after that is ignored until a read comes along. A read clears the freeze and puts the pointer back at bit 0. When the last key bit matches, the block raises `unlocked`. While it is unlocked, `mem_inhibit` marks each selected access so that the access is routed away from memory. The downstream transfer engine pulses `xfer_done` when its transfer is finished. The block then locks again with the pointer at bit 0.

Top module: `unlock_matcher`

## Requirements
- R1: After reset, `unlocked` and `mem_inhibit` are 0 and the pointer is at key bit 0.
- R2: The key is 64 bits and is presented on `acc_d0`, one bit per selected write. Bit i of the key is bit (i mod 8) of byte (i div 8 mod 4) of the sequence C5, 3A, A3, 5C, which gives LSB-first bytes C5 3A A3 5C C5 3A A3 5C. After 64 consecutive matching writes, `unlocked` reads 1 from the cycle after the 64th write.
- R3: If only 63 matching writes arrive, `unlocked` stays 0.
- R4: After a write whose bit differs from the key bit at the pointer, later writes are ignored and do not unlock, whatever their data, until a selected read occurs.
- R5: A selected read while locked returns the pointer to bit 0, so a full key sent after the read unlocks the block.
- R6: A strobe with `acc_sel` low changes neither the pointer, the freeze state nor `unlocked`.
- R7: While locked, `mem_inhibit` is 0 for every access, including the 64th key write.
- R8: While unlocked, `mem_inhibit` is 1 in exactly those cycles that carry a selected read or write, and such accesses leave `unlocked` at 1.
- R9: A `xfer_done` pulse while unlocked makes `unlocked` read 0 from the next cycle, with the pointer back at bit 0.
- R10: `xfer_done` while locked has no effect; a partly matched key continues from where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sel | input | 1 | Chip select active for this strobe |
| acc_rd | input | 1 | One-cycle read strobe |
| acc_wr | input | 1 | One-cycle write strobe |
| acc_d0 | input | 1 | Data bit 0 of the access |
| xfer_done | input | 1 | Transfer engine has finished its transfer |
| unlocked | output | 1 | Full key recognised; register transfer in progress |
| mem_inhibit | output | 1 | Current access must not reach memory |

## Verification
The hardest state to reach from the ports is a sequence that is frozen after a mismatch. A frozen sequence looks exactly like an idle one unless writes are then sent that would have finished the key. The bench therefore breaks the key at bit 20 and then sends the complete correct remainder, so that any leak of the freeze would show up as an unlock. It then confirms that a read revives the sequence from bit 0. The unlocked phase is reached by sending the full 64-bit key and then mixing selected and unselected accesses, so that the bench can see both when `mem_inhibit` goes high and when it stays low.

// File: rtl/unlock_pkg.sv
// Package: shared constants for the unlock matcher.
// Assumes the key is stored LSB-first, with bit 0 sent first.
package unlock_pkg;
    localparam int KEY_LEN = 64;
    // Bit i belongs to byte i/8; the bytes repeat C5,3A,A3,5C.
    localparam logic [KEY_LEN-1:0] KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;

    typedef enum logic {PH_LOCKED = 1'b0, PH_OPEN = 1'b1} phase_t;
endpackage

// File: rtl/unl_key_bit.sv
// Key bit selector: returns the key bit at the current pointer.
// Assumes idx < KEY_BITS; an out-of-range index reads 0.
module unl_key_bit #(
    parameter int KEY_BITS = 64,
    parameter logic [KEY_BITS-1:0] KEY = '0,
    localparam int PW = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1
) (
    input  logic [PW-1:0] idx,
    output logic          kbit
);
    // Bounded lookup of the key vector.
    always_comb begin
        kbit = 1'b0;
        for (int i = 0; i < KEY_BITS; i++)
            if (idx == PW'(i)) kbit = KEY[i];
    end
endmodule

// File: rtl/unl_seq_ptr.sv
// Sequence pointer: advances on matching writes, freezes on a mismatch,
// and is cleared by a read. It only acts while locked.
// Assumes rd_ev and wr_ev are already qualified by chip select.
module unl_seq_ptr #(
    parameter int KEY_BITS = 64,
    localparam int PW = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          locked,
    input  logic          rd_ev,
    input  logic          wr_ev,
    input  logic          d0,
    input  logic          kbit,
    output logic [PW-1:0] ptr,
    output logic          frozen,
    output logic          hit_last
);
    localparam logic [PW-1:0] LAST = PW'(KEY_BITS - 1);

    logic live_wr;
    // A write counts only while locked, not frozen and not beaten by a read.
    assign live_wr  = locked && wr_ev && !rd_ev && !frozen;
    assign hit_last = live_wr && (d0 == kbit) && (ptr == LAST);

    // Pointer and freeze flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            frozen <= 1'b0;
        end else if (locked && rd_ev) begin
            ptr    <= '0;
            frozen <= 1'b0;
        end else if (live_wr) begin
            if (d0 != kbit)     frozen <= 1'b1;
            else if (ptr == LAST) ptr  <= '0;
            else                  ptr  <= ptr + 1'b1;
        end
    end

    // R4: a frozen pointer holds until a read arrives.
    a_r4_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !rd_ev |=> $stable(ptr) && frozen);
    // R5: a read while locked clears the pointer and the freeze.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        locked && rd_ev |=> ptr == '0 && !frozen);
endmodule

// File: rtl/unl_phase.sv
// Phase tracker: moves to open when the last key bit matches and back
// to locked when the transfer engine reports completion.
// Assumes hit_last can only be raised while locked.
module unl_phase
    import unlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_last,
    input  logic xfer_done,
    output logic is_open
);
    phase_t ph;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ph <= PH_LOCKED;
        else if (ph == PH_LOCKED && hit_last)  ph <= PH_OPEN;
        else if (ph == PH_OPEN && xfer_done)   ph <= PH_LOCKED;
    end

    assign is_open = (ph == PH_OPEN);

    // R9: completion of the transfer relocks on the next cycle.
    a_r9_done_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        is_open && xfer_done |=> !is_open);
    // R2: opening requires the last key bit to have matched.
    a_r2_open_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(hit_last));
endmodule

// File: rtl/unlock_matcher.sv
// Top: serial unlock pattern matcher. Watches monitored bus strobes,
// matches the key on data bit 0 and flags accesses to divert.
// Assumes acc_rd and acc_wr are single-cycle strobes from a bus monitor.
module unlock_matcher
    import unlock_pkg::*;
#(
    parameter int KEY_BITS = KEY_LEN,
    parameter logic [KEY_BITS-1:0] KEY = KEY_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_sel,
    input  logic acc_rd,
    input  logic acc_wr,
    input  logic acc_d0,
    input  logic xfer_done,
    output logic unlocked,
    output logic mem_inhibit
);
    localparam int PW = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1;

    logic          rd_ev, wr_ev, kbit, hit_last, frozen, is_open;
    logic [PW-1:0] ptr;

    // Qualify strobes with chip select.
    assign rd_ev = acc_sel && acc_rd;
    assign wr_ev = acc_sel && acc_wr;

    unl_key_bit #(.KEY_BITS(KEY_BITS), .KEY(KEY)) u_key (
        .idx (ptr),
        .kbit(kbit)
    );

    unl_seq_ptr #(.KEY_BITS(KEY_BITS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (!is_open),
        .rd_ev   (rd_ev),
        .wr_ev   (wr_ev),
        .d0      (acc_d0),
        .kbit    (kbit),
        .ptr     (ptr),
        .frozen  (frozen),
        .hit_last(hit_last)
    );

    unl_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_last (hit_last),
        .xfer_done(xfer_done),
        .is_open  (is_open)
    );

    // Divert each selected access while open.
    assign unlocked    = is_open;
    assign mem_inhibit = is_open && (rd_ev || wr_ev);

    // R7: no diversion while locked.
    a_r7_no_inhibit_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> unlocked);
    // R6: unselected strobes disturb nothing.
    a_r6_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sel && !xfer_done |=> $stable(ptr) && $stable(frozen) && $stable(unlocked));
    // R10: the done pulse is ignored while locked.
    a_r10_done_ignored_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked && xfer_done && !acc_sel |=> $stable(ptr) && !unlocked);
endmodule

// File: tb/sim_unlock_matcher.sv
module sim_unlock_matcher;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic sel = 0, rd = 0, wr = 0, d0 = 0, done = 0;
    logic unl, inh;
    logic last_inh;
    int   n_run = 0, n_fail = 0;
    logic [7:0] kbytes [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};

    unlock_matcher u0 (.clk(clk), .rst_n(rst_n), .acc_sel(sel), .acc_rd(rd),
        .acc_wr(wr), .acc_d0(d0), .xfer_done(done), .unlocked(unl), .mem_inhibit(inh));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic kb(int i);
        return kbytes[(i / 8) % 4][i % 8];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, sample inhibit, release after edge.
    task automatic cyc(input logic s, input logic r, input logic w, input logic d, input logic dn);
        @(negedge clk);
        sel = s; rd = r; wr = w; d0 = d; done = dn;
        #1 last_inh = inh;
        @(posedge clk);
        #1 sel = 0; rd = 0; wr = 0; d0 = 0; done = 0;
    endtask

    task automatic send_bits(input int from, input int upto);
        for (int i = from; i < upto; i++) cyc(1, 0, 1, kb(i), 0);
    endtask

    task automatic relock();
        cyc(0, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        chk(unl == 0, "R1 unlocked", unl, 0);
        chk(inh == 0, "R1 inhibit", inh, 0);
    endtask

    task automatic t_full_key();
        int bad = 0;
        for (int i = 0; i < 64; i++) begin
            cyc(1, 0, 1, kb(i), 0);
            if (i < 63 && unl) bad++;
            if (last_inh) bad++;
        end
        chk(bad == 0, "R7 locked no inhibit", bad, 0);
        chk(unl == 1, "R2 unlocked after 64", unl, 1);
        relock();
        chk(unl == 0, "R9 relock", unl, 0);
    endtask

    task automatic t_short();
        send_bits(0, 63);
        chk(unl == 0, "R3 63 bits", unl, 0);
        cyc(1, 1, 0, 0, 0);
        chk(unl == 0, "R3 still locked", unl, 0);
    endtask

    task automatic t_freeze();
        send_bits(0, 20);
        cyc(1, 0, 1, ~kb(20), 0);
        send_bits(20, 64);
        chk(unl == 0, "R4 frozen", unl, 0);
        send_bits(0, 64);
        chk(unl == 0, "R4 frozen full key", unl, 0);
        cyc(1, 1, 0, 0, 0);
        send_bits(0, 64);
        chk(unl == 1, "R5 read revives", unl, 1);
        relock();
    endtask

    task automatic t_read_reset();
        send_bits(0, 30);
        cyc(1, 1, 0, 0, 0);
        send_bits(30, 64);
        chk(unl == 0, "R5 pointer back at 0", unl, 0);
        cyc(1, 1, 0, 0, 0);
        send_bits(0, 64);
        chk(unl == 1, "R5 restart unlocks", unl, 1);
        relock();
    endtask

    task automatic t_unselected();
        for (int i = 0; i < 64; i++) begin
            cyc(1, 0, 1, kb(i), 0);
            if (i % 9 == 4) begin
                cyc(0, 1, 0, 0, 0);
                cyc(0, 0, 1, ~kb(i + 1), 0);
            end
        end
        chk(unl == 1, "R6 unselected ignored", unl, 1);
        cyc(0, 1, 0, 0, 0);
        chk(last_inh == 0, "R8 unselected no inhibit", last_inh, 0);
        cyc(1, 1, 0, 0, 0);
        chk(last_inh == 1, "R8 read inhibited", last_inh, 1);
        cyc(1, 0, 1, 1, 0);
        chk(last_inh == 1, "R8 write inhibited", last_inh, 1);
        chk(unl == 1, "R8 stays open", unl, 1);
        relock();
        chk(unl == 0, "R9 relock", unl, 0);
        send_bits(0, 64);
        chk(unl == 1, "R9 pointer reset", unl, 1);
        relock();
    endtask

    task automatic t_done_locked();
        send_bits(0, 40);
        cyc(0, 0, 0, 0, 1);
        chk(unl == 0, "R10 done while locked", unl, 0);
        send_bits(40, 64);
        chk(unl == 1, "R10 progress kept", unl, 1);
        relock();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_full_key();
        t_short();
        t_freeze();
        t_read_reset();
        t_unselected();
        t_done_locked();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule